// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a four-bit up-counter, presettable and cascadable, with every state change taken on the rising clock edge. It has four operations, chosen each cycle by a fixed priority: clear to zero, load a parallel word, count up by one, or hold. The count wraps from all ones back to zero. It is meant as a building block for wide synchronous counters and programmable frequency dividers. For a divider, the terminal-count indication is fed back into the load control, so that the counter restarts from a preset value.

Counting needs two enables. The parallel enable is shared by every stage of a chain. The trickle enable is passed along the chain, and it also gates the terminal-count output. In a chain, each stage's terminal count drives the trickle enable of the next stage. The chain then counts as one wide binary counter, and no stage waits on a rippled clock.

Top module: `sbc_counter`

## Requirements
- R1: The state counts in binary modulo 2^WIDTH (modulo 16 by default), so a count from all ones (15) gives 0.
- R2: The state output changes only on a rising clock edge. Input changes between edges leave it unchanged.
- R3: When `clr_n` is low at a rising edge, the state becomes 0, whatever the load and enable inputs are.
- R4: When `clr_n` is high and `load_n` is low at a rising edge, the state takes the value of `din`, whatever the count enables are.
- R5: When `clr_n`, `load_n`, `en_p` and `en_t` are all high at a rising edge, the state increases by one.
- R6: When `clr_n` and `load_n` are high and either `en_p` or `en_t` is low, the state keeps its value across the edge.
- R7: `tc` is combinational. It is 1 exactly when the state is all ones (15) and `en_t` is high, and it does not depend on `en_p`.
- R8: In a chain of stages, stage k's `tc` drives the `en_t` of stage k+1, and all stages share `clk`, `clr_n`, `load_n` and `en_p`. Such a chain counts, loads, clears and holds as a single 4N-bit counter modulo 16^N. Its last `tc` is high only at the all-ones value while the first `en_t` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change is taken on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| din | input | 4 | Parallel preset value |
| en_p | input | 1 | Parallel count enable |
| en_t | input | 1 | Trickle count enable; also gates `tc` |
| q | output | 4 | Counter state |
| tc | output | 1 | Terminal count: state all ones and `en_t` high |

## Verification
A wrong state shows at `q` one edge after the edge that should have produced it. A wrong terminal-count decode shows at `tc` in the same cycle, because that path holds no register. A fault in the priority order appears only when two controls are active together, for example a clear with a load or a load with both enables high. The stimulus therefore mixes all four controls freely. A fault in the trickle gating stays hidden in one stage but breaks the carry between stages. It shows in the chain as a wrong wide value within one cycle of a stage boundary, at the 15-to-0 rollover of the low digit.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    // Operation applied to the state at the next rising edge
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_COUNT = 2'd2,
        OP_HOLD  = 2'd3
    } op_e;

    // Raw control levels as seen at the pins
    typedef struct packed {
        logic clr_n;
        logic load_n;
        logic en_p;
        logic en_t;
    } ctl_t;

    // Fixed precedence: clear, then load, then count, then hold
    function automatic op_e pick_op(input ctl_t c);
        if (!c.clr_n)            return OP_CLEAR;
        else if (!c.load_n)      return OP_LOAD;
        else if (c.en_p && c.en_t) return OP_COUNT;
        else                     return OP_HOLD;
    endfunction

endpackage

// File: rtl/sbc_op_decode.sv
module sbc_op_decode
    import sbc_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);
    always_comb begin
        op = pick_op(ctl);
    end
endmodule

// File: rtl/sbc_state_reg.sv
module sbc_state_reg
    import sbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  op_e              op,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] nxt;

    always_comb begin
        case (op)
            OP_CLEAR: nxt = '0;
            OP_LOAD:  nxt = din;
            OP_COUNT: nxt = q + ONE;
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        q <= nxt;
    end
endmodule

// File: rtl/sbc_tc_gen.sv
module sbc_tc_gen #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] q,
    input  logic             en_t,
    output logic             tc
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    assign tc = en_t && (q == TOP);
endmodule

// File: rtl/sbc_counter.sv
module sbc_counter
    import sbc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    input  logic             en_p,
    input  logic             en_t,
    output logic [WIDTH-1:0] q,
    output logic             tc
);
    ctl_t ctl;
    op_e  op;

    assign ctl = '{clr_n: clr_n, load_n: load_n, en_p: en_p, en_t: en_t};

    sbc_op_decode u_dec (
        .ctl (ctl),
        .op  (op)
    );

    sbc_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk (clk),
        .op  (op),
        .din (din),
        .q   (q)
    );

    sbc_tc_gen #(.WIDTH(WIDTH)) u_tc (
        .q    (q),
        .en_t (en_t),
        .tc   (tc)
    );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic [WIDTH-1:0] din,
    input logic             en_p,
    input logic             en_t,
    input logic [WIDTH-1:0] q,
    input logic             tc
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    // State is undefined until the first clear has been taken
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        armed <= armed | !clr_n;
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
        !clr_n |=> (q == '0)) else $error("clear"); // R3

    AST_LOAD_OVER_COUNT: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && !load_n) |=> (q == $past(din))) else $error("load"); // R4

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_p && en_t) |=> (q == $past(q) + ONE)) else $error("count"); // R5

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && en_p && en_t && q == TOP) |=> (q == '0)) else $error("wrap"); // R1

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
        (clr_n && load_n && !(en_p && en_t)) |=> $stable(q)) else $error("hold"); // R6

    AST_TC_AT_TOP: assert property (@(posedge clk) disable iff (!armed)
        tc |-> (q == TOP && en_t)) else $error("tc"); // R7

    AST_TC_PRESENT: assert property (@(posedge clk) disable iff (!armed)
        (q == TOP && en_t) |-> tc) else $error("tc missing"); // R7
endmodule

bind sbc_counter sbc_checker #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
    .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
);

// File: tb/tb_sbc_counter.sv
`timescale 1ns/100ps
module tb_sbc_counter;
    localparam int STAGES = 3;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    // single stage
    logic       clr_n = 1'b1, load_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
    logic [3:0] din = '0;
    logic [3:0] q;
    logic       tc;

    sbc_counter dut (
        .clk(clk), .clr_n(clr_n), .load_n(load_n), .din(din),
        .en_p(en_p), .en_t(en_t), .q(q), .tc(tc)
    );

    // chain of stages
    logic        c_clr_n = 1'b1, c_load_n = 1'b1, c_en_p = 1'b0, c_en_t = 1'b0;
    logic [11:0] c_din = '0;
    logic [3:0]  cq [STAGES];
    logic        ctc [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_chain
        logic trickle;
        if (g == 0) begin : g_first
            assign trickle = c_en_t;
        end else begin : g_next
            assign trickle = ctc[g-1];
        end
        sbc_counter stage (
            .clk(clk), .clr_n(c_clr_n), .load_n(c_load_n), .din(c_din[4*g +: 4]),
            .en_p(c_en_p), .en_t(trickle), .q(cq[g]), .tc(ctc[g])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    int mq = 0;

    // One cycle on the single stage against the behavioural model
    task automatic cycle(input bit cl, input bit ld, input int d, input bit ep, input bit et);
        string req;
        @(negedge clk);
        clr_n = cl; load_n = ld; din = d[3:0]; en_p = ep; en_t = et;
        #1;
        chk(q == mq[3:0], "R2 (no change between edges)", q, mq);
        chk(tc == (mq == 15 && et), "R7 (terminal count)", tc, (mq == 15 && et));
        @(posedge clk);
        if (!cl)            begin mq = 0;                 req = "R3 (clear)"; end
        else if (!ld)       begin mq = d & 15;            req = "R4 (load)"; end
        else if (ep && et)  begin
            req = (mq == 15) ? "R1 (wrap)" : "R5 (count)";
            mq = (mq + 1) % 16;
        end
        else                req = "R6 (hold)";
        #1;
        chk(q == mq[3:0], req, q, mq);
    endtask

    int cm = 0;

    task automatic chain_cycle(input bit cl, input bit ld, input int d, input bit ep, input bit et);
        int val;
        @(negedge clk);
        c_clr_n = cl; c_load_n = ld; c_din = d[11:0]; c_en_p = ep; c_en_t = et;
        #1;
        chk(ctc[STAGES-1] == (cm == 4095 && et), "R8 (chain terminal count)",
            ctc[STAGES-1], (cm == 4095 && et));
        @(posedge clk);
        if (!cl)           cm = 0;
        else if (!ld)      cm = d & 4095;
        else if (ep && et) cm = (cm + 1) % 4096;
        #1;
        val = {cq[2], cq[1], cq[0]};
        chk(val == cm, "R8 (chain value)", val, cm);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        // reset state
        cycle(0, 1, 9, 1, 1);
        // R3: clear beats load and enables
        cycle(1, 0, 7, 1, 1);
        cycle(0, 0, 5, 1, 1);
        // R4: load regardless of enables
        cycle(1, 0, 14, 0, 0);
        cycle(1, 0, 13, 1, 0);
        // R5/R1: count across the wrap, R7 at 15
        for (int i = 0; i < 20; i++) cycle(1, 1, 0, 1, 1);
        // R6: hold with either enable low; R7 independent of en_p at 15
        cycle(1, 0, 15, 0, 0);
        cycle(1, 1, 0, 0, 1);
        cycle(1, 1, 0, 1, 0);
        cycle(1, 1, 0, 0, 0);
        cycle(1, 1, 0, 1, 1);
        // mixed patterns
        for (int i = 0; i < 400; i++) begin
            int r = $urandom;
            cycle((r & 15) != 0, (r[7:4] != 0), int'(r[11:8]), r[12] | r[13], r[14] | r[15]);
        end

        // chain: R8
        chain_cycle(0, 1, 0, 1, 1);
        for (int i = 0; i < 4200; i++) chain_cycle(1, 1, 0, (i % 7) != 3, (i % 11) != 5);
        chain_cycle(1, 0, 12'hFFD, 0, 0);
        for (int i = 0; i < 5; i++) chain_cycle(1, 1, 0, 1, 1);
        chain_cycle(1, 0, 12'h0EF, 1, 1);
        for (int i = 0; i < 3; i++) chain_cycle(1, 1, 0, 1, 1);
        chain_cycle(0, 0, 12'h123, 1, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule